// File: doc/BRIEF.md
# Sleep Timer with Atomic Compare Loading

A free-running up-counter for low-power timekeeping. It advances once per tick pulse while its enable bit is on, and it has two compare channels and a roll-over event. Each event sets a sticky flag. Each flag can be routed to a single active-high interrupt line through a mask. Software controls the block through a plain word-addressed register bus. A write takes effect at the clock edge on which the write strobe is high. Read data is a combinational function of the address.

Each compare value is as wide as the counter, but software loads it in two half-width pieces. A write of the lower half only stages that half in a per-channel hold register. A write of the upper half loads the upper half and moves the staged lower half into the live compare value, both at the same edge. Because of this, the compare logic never sees a value made of one old half and one new half. Software is expected to change compares only while the timer is stopped, since a change while running can match early.

Top module: `stimer_top`

## Requirements
- R1: Word offsets are as follows: 0 is configuration (enable at bit 11), 1 is counter (read only), 2 is flags, 3 is mask, 4/5 is compare A upper/lower half, and 6/7 is compare B upper/lower half. After reset, every register reads zero except both lower compare halves and their hold registers, which reset to all ones within the half width. The interrupt output is low after reset.
- R2: The counter advances by exactly one on each clock edge where the tick input is high and the enable bit is 1. On every other edge it holds its value.
- R3: Writing a lower compare half changes neither that half's readback nor the value used for matching. Readback always shows the live half.
- R4: Writing an upper compare half loads bits [HALF_W-1:0] of the write data as the upper half. At the same edge, it loads the staged lower half into the live lower half.
- R5: Compare A and compare B each have their own hold register. Staging or committing one channel leaves the other channel unchanged.
- R6: A counting edge that takes the counter from all ones to zero sets flag bit 0.
- R7: A counting edge that takes the counter to a value equal to compare A sets flag bit 1. For compare B, it sets flag bit 2. While the timer is disabled, no flag is set.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. Flag bits 31:3 always read zero, whatever is written to them.
- R9: If a flag's set event and a clear write to that flag happen at the same edge, the flag ends up set.
- R10: The mask register keeps only bits 2:0, and its other bits read zero. The interrupt output is high exactly when some flag bit and the mask bit at the same position are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count pulse, one increment per high cycle while enabled |
| bus_wr_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | ADDR_W | Word address for read and write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |
| irq_o | output | 1 | Masked OR of the sticky flags |

## Verification
The bench runs the counter through more than a full wrap for several compare pairs: two distinct values, both at zero and all ones, both channels on the same value, and channel B one step past zero. It checks the count, every flag and the interrupt line after each tick. These sweeps separate compare logic that matches on the old count from logic that matches on the new count. They also catch wrap detection that is off by one, and cross-coupling between the channels. One sweep runs with a lower half staged but not committed, so a design that matches on the hold register reports the wrong match point. Directed cases cover the remaining behaviour: a clear write in the same edge as a set event, a 0 write and reserved-bit writes to the flags, ticks while disabled, and mask patterns that select only some of the flags.

// File: rtl/stimer_pkg.sv
`timescale 1ns/1ps
package stimer_pkg;
   localparam int unsigned BUS_W    = 32;
   localparam int unsigned NUM_CMP  = 2;
   localparam int unsigned NUM_FLG  = NUM_CMP + 1;
   localparam int unsigned EN_BIT   = 11;
   // word offsets; channel k: upper half at OFS_CMP0+2k, lower half one above
   localparam int unsigned OFS_CFG  = 0;
   localparam int unsigned OFS_CNT  = 1;
   localparam int unsigned OFS_FLG  = 2;
   localparam int unsigned OFS_MSK  = 3;
   localparam int unsigned OFS_CMP0 = 4;
   localparam int unsigned MIN_ADDR_W = 3;
   // flag positions: bit 0 roll-over, bit FLG_CMP0+k compare channel k
   localparam int unsigned FLG_WRAP = 0;
   localparam int unsigned FLG_CMP0 = 1;
   typedef logic [NUM_FLG-1:0] flag_vec_t;
endpackage

// File: rtl/stimer_counter.sv
`timescale 1ns/1ps
module stimer_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             step,
   output logic             wrap_ev
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign step    = en & tick;
   assign cnt_nxt = cnt_q + ONE;
   assign wrap_ev = step & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_nxt;
      end
   end
endmodule

// File: rtl/stimer_cmp.sv
`timescale 1ns/1ps
module stimer_cmp #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_we,
   input  logic              lo_we,
   input  logic [HALF_W-1:0] wdata,
   input  logic              step,
   input  logic [CNT_W-1:0]  cnt_nxt,
   output logic [CNT_W-1:0]  act,
   output logic              match_ev
);
   logic [HALF_W-1:0] hold_q;
   logic [HALF_W-1:0] lo_q;
   logic [HALF_W-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '1;
         lo_q   <= '1;
         hi_q   <= '0;
      end else begin
         if (lo_we) begin
            hold_q <= wdata;
         end
         if (hi_we) begin
            hi_q <= wdata;
            lo_q <= hold_q;
         end
      end
   end

   assign act      = {hi_q, lo_q};
   assign match_ev = step & (cnt_nxt == act);
endmodule

// File: rtl/stimer_irq.sv
`timescale 1ns/1ps
module stimer_irq #(
   parameter int unsigned NFLG = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NFLG-1:0] set,
   input  logic [NFLG-1:0] clr,
   input  logic [NFLG-1:0] mask,
   output logic [NFLG-1:0] flags,
   output logic            irq
);
   logic [NFLG-1:0] flags_d;

   // set is ORed in after the clear, so a same-edge event survives
   assign flags_d = (flags & ~clr) | set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         flags <= flags_d;
      end
   end

   assign irq = |(flags & mask);
endmodule

// File: rtl/stimer_regif.sv
`timescale 1ns/1ps
module stimer_regif
   import stimer_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned HALF_W = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            bus_wr,
   input  logic [ADDR_W-1:0]               bus_addr,
   input  logic [BUS_W-1:0]                bus_wdata,
   input  logic [CNT_W-1:0]                cnt,
   input  logic [NUM_CMP-1:0][CNT_W-1:0]   act,
   input  flag_vec_t                       flags,
   output logic                            en,
   output flag_vec_t                       mask,
   output flag_vec_t                       flg_clr,
   output logic [NUM_CMP-1:0]              hi_we,
   output logic [NUM_CMP-1:0]              lo_we,
   output logic [BUS_W-1:0]                rdata
);
   localparam logic [ADDR_W-1:0] AD_CFG = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] AD_CNT = ADDR_W'(OFS_CNT);
   localparam logic [ADDR_W-1:0] AD_FLG = ADDR_W'(OFS_FLG);
   localparam logic [ADDR_W-1:0] AD_MSK = ADDR_W'(OFS_MSK);

   logic wr_cfg;
   logic wr_msk;

   assign wr_cfg  = bus_wr && (bus_addr == AD_CFG);
   assign wr_msk  = bus_wr && (bus_addr == AD_MSK);
   assign flg_clr = (bus_wr && (bus_addr == AD_FLG)) ? bus_wdata[NUM_FLG-1:0] : '0;

   for (genvar k = 0; k < NUM_CMP; k++) begin : g_dec
      localparam logic [ADDR_W-1:0] AD_HI = ADDR_W'(OFS_CMP0 + 2 * k);
      localparam logic [ADDR_W-1:0] AD_LO = ADDR_W'(OFS_CMP0 + 2 * k + 1);
      assign hi_we[k] = bus_wr && (bus_addr == AD_HI);
      assign lo_we[k] = bus_wr && (bus_addr == AD_LO);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         mask <= '0;
      end else begin
         if (wr_cfg) begin
            en <= bus_wdata[EN_BIT];
         end
         if (wr_msk) begin
            mask <= bus_wdata[NUM_FLG-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (bus_addr == AD_CFG) rdata = BUS_W'(en) << EN_BIT;
      if (bus_addr == AD_CNT) rdata = BUS_W'(cnt);
      if (bus_addr == AD_FLG) rdata = BUS_W'(flags);
      if (bus_addr == AD_MSK) rdata = BUS_W'(mask);
      for (int k = 0; k < NUM_CMP; k++) begin
         if (bus_addr == ADDR_W'(OFS_CMP0 + 2 * k))
            rdata = BUS_W'(act[k][CNT_W-1:HALF_W]);
         if (bus_addr == ADDR_W'(OFS_CMP0 + 2 * k + 1))
            rdata = BUS_W'(act[k][HALF_W-1:0]);
      end
   end
endmodule

// File: rtl/stimer_top.sv
`timescale 1ns/1ps
module stimer_top
   import stimer_pkg::*;
#(
   parameter int unsigned HALF_W = 16,
   parameter int unsigned CNT_W  = 2 * HALF_W,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic              irq_o
);
   if (CNT_W != 2 * HALF_W) begin : g_bad_split
      $error("counter width must be twice the half width");
   end
   if (HALF_W < 1 || HALF_W > 16) begin : g_bad_half
      $error("half width must lie in 1..16");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("address width too small for the register map");
   end

   logic                          en_q;
   logic [CNT_W-1:0]              cnt_q;
   logic [CNT_W-1:0]              cnt_nxt;
   logic                          step;
   logic                          wrap_ev;
   logic [NUM_CMP-1:0][CNT_W-1:0] act;
   logic [NUM_CMP-1:0]            match_ev;
   logic [NUM_CMP-1:0]            hi_we;
   logic [NUM_CMP-1:0]            lo_we;
   flag_vec_t                     flg_set;
   flag_vec_t                     flg_clr;
   flag_vec_t                     flags;
   flag_vec_t                     mask;

   stimer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_q),
      .tick    (tick_i),
      .cnt_q   (cnt_q),
      .cnt_nxt (cnt_nxt),
      .step    (step),
      .wrap_ev (wrap_ev)
   );

   for (genvar k = 0; k < NUM_CMP; k++) begin : g_ch
      stimer_cmp #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_cmp (
         .clk      (clk),
         .rst_n    (rst_n),
         .hi_we    (hi_we[k]),
         .lo_we    (lo_we[k]),
         .wdata    (bus_wdata_i[HALF_W-1:0]),
         .step     (step),
         .cnt_nxt  (cnt_nxt),
         .act      (act[k]),
         .match_ev (match_ev[k])
      );
   end

   assign flg_set = {match_ev, wrap_ev};

   stimer_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .HALF_W(HALF_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr_i),
      .bus_addr  (bus_addr_i),
      .bus_wdata (bus_wdata_i),
      .cnt       (cnt_q),
      .act       (act),
      .flags     (flags),
      .en        (en_q),
      .mask      (mask),
      .flg_clr   (flg_clr),
      .hi_we     (hi_we),
      .lo_we     (lo_we),
      .rdata     (bus_rdata_o)
   );

   stimer_irq #(.NFLG(NUM_FLG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flg_set),
      .clr   (flg_clr),
      .mask  (mask),
      .flags (flags),
      .irq   (irq_o)
   );
endmodule

// File: rtl/stimer_chk.sv
`timescale 1ns/1ps
module stimer_chk
   import stimer_pkg::*;
#(
   parameter int unsigned HALF_W = 16,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 3
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          tick,
   input logic                          en,
   input logic [CNT_W-1:0]              cnt,
   input logic                          bus_wr,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic [31:0]                   bus_wdata,
   input logic [31:0]                   bus_rdata,
   input logic [NUM_CMP-1:0]            lo_we,
   input logic [NUM_CMP-1:0]            hi_we,
   input logic [NUM_CMP-1:0][CNT_W-1:0] act,
   input logic [NUM_FLG-1:0]            flags,
   input logic                          irq
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !(en && tick) |=> cnt == $past(cnt)); // R2
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick) |=> cnt == $past(cnt) + ONE); // R2
   AST_WRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && (&cnt)) |=> flags[FLG_WRAP]); // R6
   AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_FLG) && bus_wdata[FLG_WRAP] && !(en && tick && (&cnt)))
      |=> !flags[FLG_WRAP]); // R8
   AST_FLG_RSV: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFS_FLG)) |-> bus_rdata[31:NUM_FLG] == '0); // R8
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) |-> !irq); // R10

   for (genvar k = 0; k < NUM_CMP; k++) begin : g_ch
      AST_LO_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
         (lo_we[k] && !hi_we[k]) |=> act[k] == $past(act[k])); // R3
      AST_HI_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
         hi_we[k] |=> act[k][CNT_W-1:HALF_W] == $past(bus_wdata[HALF_W-1:0])); // R4
      AST_CMP_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (en && tick && ((cnt + ONE) == act[k])) |=> flags[FLG_CMP0 + k]); // R7
   end
endmodule

bind stimer_top stimer_chk #(.HALF_W(HALF_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick_i),
   .en        (en_q),
   .cnt       (cnt_q),
   .bus_wr    (bus_wr_i),
   .bus_addr  (bus_addr_i),
   .bus_wdata (bus_wdata_i),
   .bus_rdata (bus_rdata_o),
   .lo_we     (lo_we),
   .hi_we     (hi_we),
   .act       (act),
   .flags     (flags),
   .irq       (irq_o)
);

// File: tb/stimer_top_bench.sv
`timescale 1ns/1ps
module stimer_top_bench;
   localparam int HW = 4;
   localparam int CW = 8;
   localparam int AW = 3;
   localparam logic [2:0] A_CFG = 3'd0, A_CNT = 3'd1, A_FLG = 3'd2, A_MSK = 3'd3;
   localparam logic [2:0] A_AHI = 3'd4, A_ALO = 3'd5, A_BHI = 3'd6, A_BLO = 3'd7;
   localparam logic [31:0] EN_ON = 32'h0000_0800;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int total = 0, bad = 0;

   logic          m_en;
   logic [CW-1:0] m_cnt, m_ca, m_cb;
   logic [HW-1:0] m_ha, m_hb;
   logic [2:0]    m_flg, m_msk;

   always #2.5 clk = ~clk;

   stimer_top #(.HALF_W(HW), .CNT_W(CW), .ADDR_W(AW)) u_stimer_top (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
   );

   task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic model_write(input logic [2:0] a, input logic [31:0] d);
      case (a)
         A_CFG: m_en = d[11];
         A_FLG: m_flg = m_flg & ~d[2:0];
         A_MSK: m_msk = d[2:0];
         A_ALO: m_ha = d[HW-1:0];
         A_AHI: m_ca = {d[HW-1:0], m_ha};
         A_BLO: m_hb = d[HW-1:0];
         A_BHI: m_cb = {d[HW-1:0], m_hb};
         default: ;
      endcase
   endtask

   function automatic logic [2:0] events();
      logic [CW-1:0] nx;
      logic [2:0] ev;
      nx = m_cnt + 1'b1;
      ev = '0;
      if (m_en) begin
         ev[0] = (m_cnt == '1);
         ev[1] = (nx == m_ca);
         ev[2] = (nx == m_cb);
      end
      return ev;
   endfunction

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic tick_once();
      logic [2:0] ev;
      ev = events();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (m_en) m_cnt = m_cnt + 1'b1;
      m_flg = m_flg | ev;
   endtask

   // tick and bus write land on the same edge
   task automatic tick_write(input logic [2:0] a, input logic [31:0] d);
      logic [2:0] ev;
      ev = events();
      @(negedge clk);
      tick = 1'b1; addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      tick = 1'b0; wr = 1'b0;
      model_write(a, d);
      m_flg = m_flg | ev;
      if (m_en) m_cnt = m_cnt + 1'b1;
   endtask

   task automatic check_state(input string tag);
      logic [31:0] d;
      bus_read(A_CNT, d);
      check("R2", {tag, " count"}, d, 32'(m_cnt));
      bus_read(A_FLG, d);
      check("R6/R7", {tag, " flags"}, d, 32'(m_flg));
      check("R10", {tag, " irq"}, 32'(irq), 32'(|(m_flg & m_msk)));
   endtask

   task automatic sweep(input logic [CW-1:0] ca, input logic [CW-1:0] cb,
                        input logic [2:0] msk, input bit stage, input logic [HW-1:0] stage_lo);
      bus_write(A_CFG, 32'h0);
      bus_write(A_ALO, 32'(ca[HW-1:0]));
      bus_write(A_AHI, 32'(ca[CW-1:HW]));
      bus_write(A_BLO, 32'(cb[HW-1:0]));
      bus_write(A_BHI, 32'(cb[CW-1:HW]));
      if (stage) bus_write(A_ALO, 32'(stage_lo)); // R3: staged only, must not move the match point
      bus_write(A_FLG, 32'h7);
      bus_write(A_MSK, 32'(msk));
      bus_write(A_CFG, EN_ON);
      for (int i = 0; i < 260; i++) begin
         tick_once();
         check_state("sweep");
         if (m_flg != '0) bus_write(A_FLG, 32'h7);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [CW-1:0] tgt;
      m_en = 0; m_cnt = '0; m_ca = 8'h0F; m_cb = 8'h0F; m_ha = 4'hF; m_hb = 4'hF;
      m_flg = '0; m_msk = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      bus_read(A_CFG, d); check("R1", "cfg", d, 32'h0);
      bus_read(A_CNT, d); check("R1", "count", d, 32'h0);
      bus_read(A_FLG, d); check("R1", "flags", d, 32'h0);
      bus_read(A_MSK, d); check("R1", "mask", d, 32'h0);
      bus_read(A_AHI, d); check("R1", "A hi", d, 32'h0);
      bus_read(A_ALO, d); check("R1", "A lo", d, 32'hF);
      bus_read(A_BHI, d); check("R1", "B hi", d, 32'h0);
      bus_read(A_BLO, d); check("R1", "B lo", d, 32'hF);
      check("R1", "irq", 32'(irq), 32'h0);

      // R2 ticks while disabled, then enabled, then idle cycles
      for (int i = 0; i < 3; i++) tick_once();
      check_state("R2 disabled");
      bus_write(A_CFG, EN_ON);
      bus_read(A_CFG, d); check("R1", "cfg enable bit 11", d, EN_ON);
      for (int i = 0; i < 3; i++) tick_once();
      repeat (4) @(negedge clk);
      check_state("R2 enabled");

      // R3 R4 R5 split loading
      bus_write(A_CFG, 32'h0);
      bus_write(A_ALO, 32'h5);
      bus_read(A_ALO, d); check("R3", "A lo after stage", d, 32'hF);
      bus_write(A_AHI, 32'h3);
      bus_read(A_AHI, d); check("R4", "A hi after commit", d, 32'h3);
      bus_read(A_ALO, d); check("R4", "A lo after commit", d, 32'h5);
      bus_read(A_BLO, d); check("R5", "B lo untouched", d, 32'hF);
      bus_write(A_BLO, 32'hA);
      bus_write(A_BHI, 32'h1);
      bus_read(A_BHI, d); check("R5", "B hi", d, 32'h1);
      bus_read(A_BLO, d); check("R5", "B lo", d, 32'hA);
      bus_read(A_ALO, d); check("R5", "A lo unaffected by B", d, 32'h5);
      bus_read(A_AHI, d); check("R5", "A hi unaffected by B", d, 32'h3);

      // sweeps over more than one wrap (R6 R7 R3 R10)
      sweep(8'h35, 8'h1A, 3'b101, 1'b1, 4'h9);
      sweep(8'h00, 8'hFF, 3'b111, 1'b0, 4'h0);
      sweep(8'h80, 8'h80, 3'b010, 1'b0, 4'h0);
      sweep(8'hFF, 8'h01, 3'b100, 1'b1, 4'h2);

      // R7 no events while disabled
      bus_write(A_CFG, 32'h0);
      tgt = m_cnt + 1'b1;
      bus_write(A_ALO, 32'(tgt[HW-1:0]));
      bus_write(A_AHI, 32'(tgt[CW-1:HW]));
      bus_write(A_FLG, 32'h7);
      tick_once(); tick_once();
      check_state("R7 disabled");

      // R9 set wins over a same-edge clear
      bus_write(A_CFG, EN_ON);
      tick_write(A_FLG, 32'h2);
      check_state("R9");
      bus_read(A_FLG, d); check("R9", "A flag survives clear", 32'(d[1]), 32'h1);

      // R8 clear semantics
      while (!m_flg[0]) tick_once();
      check_state("R8 setup");
      bus_write(A_FLG, 32'h0);
      bus_read(A_FLG, d); check("R8", "write zero keeps", d, 32'(m_flg));
      bus_write(A_FLG, 32'hFFFF_FFF8);
      bus_read(A_FLG, d); check("R8", "reserved write", d, 32'(m_flg));
      bus_write(A_FLG, 32'h1);
      bus_read(A_FLG, d); check("R8", "wrap bit cleared", 32'(d[0]), 32'h0);
      check("R8", "other bits kept", d, 32'(m_flg));

      // R10 mask selection
      bus_write(A_CFG, 32'h0);
      bus_write(A_MSK, 32'h0);
      check("R10", "irq masked", 32'(irq), 32'h0);
      bus_write(A_MSK, 32'hFFFF_FFFF);
      bus_read(A_MSK, d); check("R10", "mask width", d, 32'h7);
      check("R10", "irq unmasked", 32'(irq), 32'(|m_flg));
      bus_write(A_FLG, 32'h7);
      check("R10", "irq after clear", 32'(irq), 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule